// File: doc/BRIEF.md
# Hysteretic LED Current Command Regulator

This block closes a slow outer loop around a two-stage LED driver. Once per half-line cycle an update strobe arrives with the digitised boost output voltage, given as a fraction of full scale. The block then moves a 10-bit LED current command so that the boost voltage settles inside a regulation window. Inside the window nothing changes. Outside it the command moves in steps that grow on each consecutive update. Deep below the window, or while the output clamp is dissipating excess energy, the steps are four times larger.

When the command already sits at its maximum and the voltage is still too high, the block lowers an 8-bit boost-current scale factor instead of the command. When the voltage later drops too low, that scale is first brought back to nominal, and only after that does the command start to fall. A variant-select input moves the lower thresholds to the values used by the higher-voltage product variant. The command never drops below 5 % of full output.

Top module: `hyst_iout_loop`

## Requirements
- R1: Synchronous active-low reset sets the command to 512, the boost scale to nominal (255) and the step size to 1.
- R2: An update with the voltage code inside the window (not above the high threshold, not below the low threshold) and the clamp flag low leaves both outputs unchanged.
- R3: With an 8-bit voltage code, "above high" means code > 209 (82.0 %). "Below low" means code < 153 (60.0 %), or code < 168 (65.9 %) when the variant-select input is 1.
- R4: Consecutive updates in the increase direction use steps of 1, 2, 4, … doubling up to a cap of 32. The command saturates at 1023.
- R5: Consecutive updates in the decrease direction use the same doubling, capped step sequence.
- R6: Below the accelerated-decrease threshold, code < 133 (52.2 %) or code < 154 (60.4 %) with variant select 1, the decrement is 4 times the current step.
- R7: While the clamp-active flag is 1, an update is an increase of 4 times the current step, whatever the voltage code is. The clamp flag is asserted by the clamp logic from 87.8 % until the voltage falls below 85.1 %.
- R8: The step returns to 1 when an update finds the voltage inside the window. The step also restarts at 1 when the direction reverses.
- R9: An increase-direction update with the command at 1023 leaves the command unchanged and lowers the boost scale by the amount, flooring at 0.
- R10: A decrease-direction update with the boost scale below 255 raises the scale by the amount, saturating at 255, and leaves the command unchanged.
- R11: The command never goes below 52 (5 % of 1023). A decrement that would cross the floor lands on it.
- R12: Without the update strobe, neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_stb | input | 1 | One-cycle strobe, once per half-line cycle |
| vbst_code | input | 8 | Boost output voltage, fraction of full scale (255 ≈ 100 %) |
| clamp_act | input | 1 | Output clamp currently active |
| alt_sel | input | 1 | Selects the higher lower-threshold variant |
| iout_cmd | output | 10 | LED output current command |
| bst_scale | output | 8 | Boost inductor current scale, 255 = nominal |

## Verification
On every cycle the embedded properties check a set of invariants. The command floor holds. Outputs stay still without a strobe and inside the window. An increase moves the command up unless it is saturated. A reduced boost scale only ever coexists with a saturated command. The step stays a capped power of two.

The exact step sequences cannot be seen by those properties and only the bench's scenarios show them. That covers the growing steps, the fourfold accelerated zones, the threshold boundaries in both variants, the step restart on window re-entry or reversal, and the order of scale recovery before command reduction. The bench checks these by comparing against its behavioural model every cycle.

// File: rtl/hyst_loop_pkg.sv
// Shared types and helpers for the hysteretic current regulator.
// Assumes voltage codes are unsigned fractions of full scale.
package hyst_loop_pkg;

    // Regulation zone of one update, increase zones first
    typedef enum logic [2:0] {
        Z_HOLD    = 3'd0,
        Z_UP      = 3'd1,
        Z_UP_FAST = 3'd2,
        Z_DN      = 3'd3,
        Z_DN_FAST = 3'd4
    } zone_t;

    // Convert a per-mille threshold into a code of the given width (truncating)
    function automatic int unsigned pm_to_code(input int unsigned pm, input int unsigned bits);
        return (pm * (32'd1 << bits)) / 1000;
    endfunction

endpackage

// File: rtl/hyst_zone_sel.sv
// Classifies the current voltage code into a regulation zone.
// Clamp activity has top priority, then the high threshold, then the
// accelerated-decrease threshold, then the low threshold.
// Assumes: thresholds ordered DEC < LO < HI in both variants.
module hyst_zone_sel
    import hyst_loop_pkg::*;
#(
    parameter int unsigned VB_W       = 8,
    parameter int unsigned HI_PM      = 820,
    parameter int unsigned LO_PM      = 600,
    parameter int unsigned LO_ALT_PM  = 659,
    parameter int unsigned DEC_PM     = 522,
    parameter int unsigned DEC_ALT_PM = 604
) (
    input  logic [VB_W-1:0] vbst_code,
    input  logic            clamp_act,
    input  logic            alt_sel,
    output zone_t           zone
);
    localparam logic [VB_W-1:0] HI_C      = VB_W'(pm_to_code(HI_PM, VB_W));
    localparam logic [VB_W-1:0] LO_C      = VB_W'(pm_to_code(LO_PM, VB_W));
    localparam logic [VB_W-1:0] LO_ALT_C  = VB_W'(pm_to_code(LO_ALT_PM, VB_W));
    localparam logic [VB_W-1:0] DEC_C     = VB_W'(pm_to_code(DEC_PM, VB_W));
    localparam logic [VB_W-1:0] DEC_ALT_C = VB_W'(pm_to_code(DEC_ALT_PM, VB_W));

    logic [VB_W-1:0] lo_th, dec_th;

    // Pick the variant's lower thresholds
    always_comb begin
        lo_th  = alt_sel ? LO_ALT_C  : LO_C;
        dec_th = alt_sel ? DEC_ALT_C : DEC_C;
    end

    // Prioritised zone decision
    always_comb begin
        if (clamp_act)              zone = Z_UP_FAST;
        else if (vbst_code > HI_C)  zone = Z_UP;
        else if (vbst_code < dec_th) zone = Z_DN_FAST;
        else if (vbst_code < lo_th) zone = Z_DN;
        else                        zone = Z_HOLD;
    end
endmodule

// File: rtl/hyst_step_gen.sv
// Produces the adjustment amount of each update. The step doubles on
// consecutive updates in one direction up to 2**STEP_LOG, restarts at 1 on
// reversal or window re-entry; accelerated zones multiply by 2**ACC_SH.
// Assumes: upd is a single-cycle strobe.
module hyst_step_gen
    import hyst_loop_pkg::*;
#(
    parameter int unsigned STEP_LOG = 5,
    parameter int unsigned ACC_SH   = 2,
    parameter int unsigned STEP_W   = STEP_LOG + 1,
    parameter int unsigned AMT_W    = STEP_W + ACC_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  zone_t            zone,
    output logic [AMT_W-1:0] amount
);
    typedef enum logic [1:0] {D_NONE, D_RISE, D_FALL} dir_t;

    localparam logic [STEP_W-1:0] CAP = STEP_W'(1) << STEP_LOG;

    logic [STEP_W-1:0] step_q, base, step_n;
    dir_t              dir_q, dir_n;
    logic              rising, falling, fast;

    // Decode direction and acceleration of the present zone
    always_comb begin
        rising  = (zone == Z_UP) || (zone == Z_UP_FAST);
        falling = (zone == Z_DN) || (zone == Z_DN_FAST);
        fast    = (zone == Z_UP_FAST) || (zone == Z_DN_FAST);
    end

    // Amount used now and step to remember for the next update
    always_comb begin
        base   = ((rising && dir_q == D_RISE) || (falling && dir_q == D_FALL)) ? step_q : STEP_W'(1);
        amount = fast ? (AMT_W'(base) << ACC_SH) : AMT_W'(base);
        step_n = (base >= CAP) ? CAP : (base << 1);
        dir_n  = rising ? D_RISE : (falling ? D_FALL : D_NONE);
    end

    // Step and direction registers, advanced only on an update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= STEP_W'(1);
            dir_q  <= D_NONE;
        end else if (upd) begin
            step_q <= (dir_n == D_NONE) ? STEP_W'(1) : step_n;
            dir_q  <= dir_n;
        end
    end

    // R4
    step_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(step_q));
    // R5
    step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) step_q <= CAP);
    // R8
    step_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && zone == Z_HOLD) |=> (step_q == STEP_W'(1)));
endmodule

// File: rtl/hyst_cmd_reg.sv
// Holds the LED current command and the boost current scale. Increases
// go to the command until it saturates, then reduce the scale; decreases
// first restore the scale to nominal, then lower the command to its floor.
// Assumes: amount is at most the full range of either register.
module hyst_cmd_reg
    import hyst_loop_pkg::*;
#(
    parameter int unsigned CMD_W    = 10,
    parameter int unsigned SCALE_W  = 8,
    parameter int unsigned AMT_W    = 8,
    parameter int unsigned CMD_INIT = 512,
    parameter int unsigned FLOOR_PC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  zone_t              zone,
    input  logic [AMT_W-1:0]   amount,
    output logic [CMD_W-1:0]   cmd,
    output logic [SCALE_W-1:0] scale
);
    localparam int unsigned CMD_MAX = (1 << CMD_W) - 1;
    localparam int unsigned SC_NOM  = (1 << SCALE_W) - 1;
    localparam int unsigned FLOOR   = (CMD_MAX * FLOOR_PC + 99) / 100;
    localparam int unsigned W_A     = (CMD_W > SCALE_W) ? CMD_W : SCALE_W;
    localparam int unsigned EXT_W   = ((W_A > AMT_W) ? W_A : AMT_W) + 1;

    logic [EXT_W-1:0]   cmd_x, scl_x, amt_x;
    logic [CMD_W-1:0]   cmd_n;
    logic [SCALE_W-1:0] scl_n;
    logic               rising, falling;

    // Widen operands so sums and differences cannot wrap
    always_comb begin
        cmd_x   = EXT_W'(cmd);
        scl_x   = EXT_W'(scale);
        amt_x   = EXT_W'(amount);
        rising  = (zone == Z_UP) || (zone == Z_UP_FAST);
        falling = (zone == Z_DN) || (zone == Z_DN_FAST);
    end

    // Next values of command and scale with saturation and handover
    always_comb begin
        cmd_n = cmd;
        scl_n = scale;
        if (rising) begin
            if (cmd_x == EXT_W'(CMD_MAX))
                scl_n = (scl_x > amt_x) ? SCALE_W'(scl_x - amt_x) : '0;
            else if (cmd_x + amt_x >= EXT_W'(CMD_MAX))
                cmd_n = CMD_W'(CMD_MAX);
            else
                cmd_n = CMD_W'(cmd_x + amt_x);
        end else if (falling) begin
            if (scl_x != EXT_W'(SC_NOM))
                scl_n = (scl_x + amt_x >= EXT_W'(SC_NOM)) ? SCALE_W'(SC_NOM) : SCALE_W'(scl_x + amt_x);
            else if (cmd_x <= EXT_W'(FLOOR) + amt_x)
                cmd_n = CMD_W'(FLOOR);
            else
                cmd_n = CMD_W'(cmd_x - amt_x);
        end
    end

    // Output registers, loaded only on an update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd   <= CMD_W'(CMD_INIT);
            scale <= SCALE_W'(SC_NOM);
        end else if (upd) begin
            cmd   <= cmd_n;
            scale <= scl_n;
        end
    end

    // R11
    cmd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd >= CMD_W'(FLOOR));
    // R12
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(cmd) && $stable(scale)));
    // R2
    window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && zone == Z_HOLD) |=> ($stable(cmd) && $stable(scale)));
    // R9
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scale != SCALE_W'(SC_NOM)) |-> (cmd == CMD_W'(CMD_MAX)));
    // R4
    rise_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && rising && cmd != CMD_W'(CMD_MAX)) |=> (cmd > $past(cmd)));
    // R10
    recover_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && falling && scale != SCALE_W'(SC_NOM)) |=> ($stable(cmd) && scale > $past(scale)));
endmodule

// File: rtl/hyst_iout_loop.sv
// Top of the hysteretic LED current regulator: zone decision, step
// generation and command/scale registers. One update per upd_stb pulse.
// Assumes: vbst_code and clamp_act are stable in the cycle of the strobe.
module hyst_iout_loop
    import hyst_loop_pkg::*;
#(
    parameter int unsigned VB_W     = 8,
    parameter int unsigned CMD_W    = 10,
    parameter int unsigned SCALE_W  = 8,
    parameter int unsigned STEP_LOG = 5,
    parameter int unsigned ACC_SH   = 2,
    parameter int unsigned CMD_INIT = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_stb,
    input  logic [VB_W-1:0]    vbst_code,
    input  logic               clamp_act,
    input  logic               alt_sel,
    output logic [CMD_W-1:0]   iout_cmd,
    output logic [SCALE_W-1:0] bst_scale
);
    localparam int unsigned STEP_W = STEP_LOG + 1;
    localparam int unsigned AMT_W  = STEP_W + ACC_SH;

    zone_t            zone;
    logic [AMT_W-1:0] amount;

    hyst_zone_sel #(.VB_W(VB_W)) u_zone (
        .vbst_code (vbst_code),
        .clamp_act (clamp_act),
        .alt_sel   (alt_sel),
        .zone      (zone)
    );

    hyst_step_gen #(
        .STEP_LOG (STEP_LOG),
        .ACC_SH   (ACC_SH),
        .STEP_W   (STEP_W),
        .AMT_W    (AMT_W)
    ) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd_stb),
        .zone   (zone),
        .amount (amount)
    );

    hyst_cmd_reg #(
        .CMD_W    (CMD_W),
        .SCALE_W  (SCALE_W),
        .AMT_W    (AMT_W),
        .CMD_INIT (CMD_INIT)
    ) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd_stb),
        .zone   (zone),
        .amount (amount),
        .cmd    (iout_cmd),
        .scale  (bst_scale)
    );
endmodule

// File: tb/tb_hyst_iout_loop.sv
module tb_hyst_iout_loop;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic [7:0] vbst_code = 8'd180;
    logic       clamp_act = 1'b0;
    logic       alt_sel = 1'b0;
    logic [9:0] iout_cmd;
    logic [7:0] bst_scale;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_cmd = 512, m_scl = 255, m_step = 1, m_dir = 0;

    always #2 clk = ~clk;

    hyst_iout_loop dut (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .vbst_code(vbst_code),
        .clamp_act(clamp_act), .alt_sel(alt_sel), .iout_cmd(iout_cmd), .bst_scale(bst_scale)
    );

    // Reference model straight from the requirement text
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 512; m_scl = 255; m_step = 1; m_dir = 0;
        end else if (upd_stb) begin
            int v, lo, dc, d, amt, base;
            bit acc;
            v  = vbst_code;
            lo = alt_sel ? 168 : 153;
            dc = alt_sel ? 154 : 133;
            if (clamp_act)   begin d = 1;  acc = 1; end
            else if (v > 209) begin d = 1;  acc = 0; end
            else if (v < dc) begin d = -1; acc = 1; end
            else if (v < lo) begin d = -1; acc = 0; end
            else             begin d = 0;  acc = 0; end
            if (d == 0) begin
                m_step = 1; m_dir = 0;
            end else begin
                base = (m_dir == d) ? m_step : 1;
                amt  = acc ? base * 4 : base;
                m_step = (base * 2 > 32) ? 32 : base * 2;
                m_dir  = d;
                if (d == 1) begin
                    if (m_cmd == 1023) m_scl = (m_scl - amt < 0) ? 0 : m_scl - amt;
                    else m_cmd = (m_cmd + amt > 1023) ? 1023 : m_cmd + amt;
                end else begin
                    if (m_scl < 255) m_scl = (m_scl + amt > 255) ? 255 : m_scl + amt;
                    else m_cmd = (m_cmd - amt < 52) ? 52 : m_cmd - amt;
                end
            end
        end
    end

    task automatic compare(input string req);
        checks++;
        if (iout_cmd !== 10'(m_cmd)) begin
            fails++;
            $display("FAIL %s iout_cmd actual %0d expected %0d at %0t", req, iout_cmd, m_cmd, $time);
        end
        checks++;
        if (bst_scale !== 8'(m_scl)) begin
            fails++;
            $display("FAIL %s bst_scale actual %0d expected %0d at %0t", req, bst_scale, m_scl, $time);
        end
    endtask

    // Drive n cycles with given inputs, compare on each falling edge
    task automatic run(input int vb, input bit cl, input bit alt, input bit up, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            vbst_code = 8'(vb); clamp_act = cl; alt_sel = alt; upd_stb = up;
            @(posedge clk);
            @(negedge clk);
            compare(req);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R12 watchdog expired actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) begin @(posedge clk); @(negedge clk); compare("R1"); end
        rst_n = 1'b1;
        run(180, 0, 0, 1, 4, "R2");          // inside window
        run(240, 0, 0, 0, 5, "R12");         // no strobe: no change
        run(220, 0, 0, 1, 8, "R4");          // 1,2,4,...,32,32
        run(180, 0, 0, 1, 1, "R8");          // re-enter window
        run(220, 0, 0, 1, 2, "R8");          // restarts at 1
        run(140, 0, 0, 1, 1, "R8");          // reversal restarts at 1
        run(209, 0, 0, 1, 2, "R3");          // exactly high: hold
        run(210, 0, 0, 1, 1, "R3");          // just above
        run(153, 0, 0, 1, 1, "R3");          // exactly low: hold
        run(152, 0, 0, 1, 1, "R3");          // just below
        run(160, 0, 1, 1, 1, "R3");          // below alternate low
        run(168, 0, 1, 1, 1, "R3");          // alternate low: hold
        run(140, 0, 0, 1, 7, "R5");
        run(180, 0, 0, 1, 1, "R2");
        run(120, 0, 0, 1, 3, "R6");
        run(150, 0, 1, 1, 2, "R6");          // alternate accelerated zone
        run(100, 0, 0, 1, 20, "R11");        // drive to the floor
        run(150, 1, 0, 1, 10, "R7");         // clamp wins over low code
        run(230, 0, 0, 1, 12, "R9");         // saturated: scale down
        run(140, 0, 0, 1, 12, "R10");        // scale back up first
        begin
            logic [7:0] lf = 8'hA5;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                run(int'(lf), lf[7:5] == 3'd7, lf[1], lf[0] | lf[2], 1, "R4");
            end
        end
        run(180, 0, 0, 0, 2, "R12");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule